// File: doc/BRIEF.md
# Multiprocessor Boot Sequencer

This block orders the start-up of a cluster of processors that share one external bus and one boot ROM. At the first clock edge after reset is released it captures a three-bit strap code for each processor and turns it into one of four boot modes: ROM, host, link or no-boot. Processor 0 has its own strap inputs. All the other processors share a single strap group.

Processors that boot from the shared ROM get the bus one at a time, in fixed priority order. Each keeps the bus and the ROM select until it reports that its boot is done. An external host may request the bus. It is granted the bus only in the gaps between processor transfers. When every processor has finished booting, a common run signal tells them all to start executing. The block also reports each processor's decoded mode and its initial program address.

Top module: `mp_boot_seq`

## Requirements
- R1: The strap code {rom, link, sel} decodes as follows. rom=1 gives ROM mode (code 3). rom=0 with link=1 gives link mode (code 2). 001 gives host mode (code 1). 000 gives no-boot (code 0). Processor i's code appears on boot_mode[2i+1:2i].
- R2: Processor 0 takes its mode from strap_lead. Processors 1 to NPROC-1 all take their mode from strap_group.
- R3: The straps are captured on the first rising edge after rst_n goes high. Later strap changes affect neither boot_mode, start_addr nor the grant order until the next reset.
- R4: Processor i's slot start_addr[32i+31:32i] holds 0x0040_0004 in no-boot mode and 0x0002_0000 in every other mode.
- R5: ROM-mode processors receive bus_gnt one at a time, lowest index first. The grant holds until that processor's boot_done. The next grant comes one idle cycle later.
- R6: bus_gnt is at most one-hot. rom_cs is high exactly while a processor holds bus_gnt. host_gnt and bus_gnt are never high together.
- R7: host_gnt rises on the edge after host_req is seen while the bus is idle, and it takes precedence over waiting processors. host_gnt never rises during a processor transfer. It falls on the edge after host_req drops.
- R8: No-boot processors count as done at the capture edge. Host and link processors are done on their boot_done. A ROM processor's boot_done counts only while it holds the bus.
- R9: run goes high once all processors are done and stays high until reset.
- R10: While in reset, bus_gnt, host_gnt, rom_cs, run, boot_mode and start_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_lead | input | 3 | Strap code of processor 0 {rom, link, sel} |
| strap_group | input | 3 | Strap code shared by processors 1 and up |
| boot_done | input | NPROC | Per-processor boot-complete pulse |
| host_req | input | 1 | Host bus request |
| host_gnt | output | 1 | Host bus grant |
| bus_gnt | output | NPROC | Per-processor bus grant |
| rom_cs | output | 1 | Boot ROM select |
| run | output | 1 | Start execution, shared by all processors |
| boot_mode | output | 2*NPROC | Decoded mode per processor |
| start_addr | output | NPROC*ADDR_W | Initial program address per processor |

## Verification
Mode and address outputs are due right after the capture edge, and run is due on the same edge as the boot_done that completes the set. A grant falls on the boot_done edge. The next processor grant or the host grant follows one edge later. host_gnt falls one edge after host_req drops. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the edge where each result is due. Pulses last exactly one cycle, so the cycle of every transition is checked directly.

// File: rtl/mp_boot_seq.sv
module mp_boot_seq #(
  parameter int NPROC = 4,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] NOBOOT_ADDR = 32'h0040_0004,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = 32'h0002_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                strap_lead,
  input  logic [2:0]                strap_group,
  input  logic [NPROC-1:0]          boot_done,
  input  logic                      host_req,
  output logic                      host_gnt,
  output logic [NPROC-1:0]          bus_gnt,
  output logic                      rom_cs,
  output logic                      run,
  output logic [2*NPROC-1:0]        boot_mode,
  output logic [NPROC*ADDR_W-1:0]   start_addr
);
  localparam int IDX_W = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam logic [1:0] M_NONE = 2'd0, M_HOST = 2'd1, M_LINK = 2'd2, M_ROM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_PROC, S_HOST} st_t;

  function automatic logic [1:0] decode(input logic [2:0] s);
    if (s[2])      return M_ROM;
    else if (s[1]) return M_LINK;
    else if (s[0]) return M_HOST;
    else           return M_NONE;
  endfunction

  logic               sampled;
  logic [2*NPROC-1:0] mode_q;
  logic [NPROC-1:0]   done_q;
  logic [NPROC-1:0]   pend;
  logic [IDX_W-1:0]   owner, nxt;
  st_t                st;

  wire [1:0] lead_mode  = decode(strap_lead);
  wire [1:0] group_mode = decode(strap_group);

  always_comb begin
    for (int i = 0; i < NPROC; i++)
      pend[i] = (mode_q[2*i +: 2] == M_ROM) && !done_q[i];
    nxt = '0;
    for (int i = NPROC-1; i >= 0; i--)
      if (pend[i]) nxt = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled <= 1'b0;
      mode_q  <= '0;
      done_q  <= '0;
      st      <= S_IDLE;
      owner   <= '0;
    end else if (!sampled) begin
      sampled <= 1'b1;
      for (int i = 0; i < NPROC; i++) begin
        mode_q[2*i +: 2] <= (i == 0) ? lead_mode : group_mode;
        done_q[i]        <= (((i == 0) ? lead_mode : group_mode) == M_NONE);
      end
    end else begin
      for (int i = 0; i < NPROC; i++)
        if (boot_done[i] && (mode_q[2*i +: 2] == M_HOST || mode_q[2*i +: 2] == M_LINK))
          done_q[i] <= 1'b1;
      case (st)
        S_IDLE: begin
          if (host_req) st <= S_HOST;
          else if (|pend) begin
            st    <= S_PROC;
            owner <= nxt;
          end
        end
        S_PROC: begin
          if (boot_done[owner]) begin
            done_q[owner] <= 1'b1;
            st            <= S_IDLE;
          end
        end
        S_HOST: if (!host_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_gnt   = (st == S_PROC) ? (NPROC'(1) << owner) : '0;
  assign rom_cs    = (st == S_PROC);
  assign host_gnt  = (st == S_HOST);
  assign run       = sampled & (&done_q);
  assign boot_mode = mode_q;

  for (genvar g = 0; g < NPROC; g++) begin : g_addr
    assign start_addr[g*ADDR_W +: ADDR_W] = !sampled ? '0 :
      (mode_q[2*g +: 2] == M_NONE) ? NOBOOT_ADDR : BOOT_ADDR;
  end
endmodule

// File: rtl/mp_boot_seq_chk.sv
module mp_boot_seq_chk #(
  parameter int NPROC = 4,
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPROC-1:0]        boot_done,
  input logic                    host_req,
  input logic                    host_gnt,
  input logic [NPROC-1:0]        bus_gnt,
  input logic                    run,
  input logic [2*NPROC-1:0]      boot_mode,
  input logic [NPROC*ADDR_W-1:0] start_addr
);
  a_r6_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  a_r6_host_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && (|bus_gnt)));

  a_r5_gnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bus_gnt) && !(|(bus_gnt & boot_done))) |=> $stable(bus_gnt));

  a_r7_no_mid_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_gnt) |=> !host_gnt);

  a_r7_host_release: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !host_req) |=> !host_gnt);

  a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);

  a_r3_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_addr) |=> ($stable(start_addr) && $stable(boot_mode)));
endmodule

bind mp_boot_seq mp_boot_seq_chk #(.NPROC(NPROC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .host_req(host_req),
  .host_gnt(host_gnt), .bus_gnt(bus_gnt), .run(run),
  .boot_mode(boot_mode), .start_addr(start_addr)
);

// File: tb/mp_boot_seq_tb.sv
`timescale 1ns/1ps
module mp_boot_seq_tb;
  localparam logic [31:0] NB = 32'h0040_0004;
  localparam logic [31:0] BT = 32'h0002_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   strap_lead = '0, strap_group = '0;
  logic [3:0]   boot_done = '0;
  logic         host_req = 1'b0;
  logic         host_gnt, rom_cs, run;
  logic [3:0]   bus_gnt;
  logic [7:0]   boot_mode;
  logic [127:0] start_addr;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mp_boot_seq u_dut (
    .clk(clk), .rst_n(rst_n), .strap_lead(strap_lead), .strap_group(strap_group),
    .boot_done(boot_done), .host_req(host_req), .host_gnt(host_gnt),
    .bus_gnt(bus_gnt), .rom_cs(rom_cs), .run(run),
    .boot_mode(boot_mode), .start_addr(start_addr)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [3:0] v);
    boot_done = v;
    tick();
    boot_done = '0;
  endtask

  task automatic start(input logic [2:0] lead, input logic [2:0] grp);
    rst_n = 1'b0;
    strap_lead = lead;
    strap_group = grp;
    host_req = 1'b0;
    boot_done = '0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    strap_lead = 3'b100;
    strap_group = 3'b000;
    tick();
    tick();
    chk("R10 bus_gnt in reset", 128'(bus_gnt), 0);
    chk("R10 host/rom/run in reset", 128'({host_gnt, rom_cs, run}), 0);
    chk("R10 boot_mode in reset", 128'(boot_mode), 0);
    chk("R10 start_addr in reset", start_addr, 0);
  endtask

  task automatic t_rom_chain();
    start(3'b100, 3'b111);
    chk("R1 R2 all rom modes", 128'(boot_mode), 128'h0FF);
    chk("R4 boot addr", start_addr, {4{BT}});
    tick();
    chk("R5 first grant proc0", 128'(bus_gnt), 128'h1);
    chk("R6 rom_cs with grant", 128'(rom_cs), 1);
    tick();
    tick();
    chk("R5 grant held", 128'(bus_gnt), 128'h1);
    pulse(4'b0001);
    chk("R5 grant drops on done", 128'(bus_gnt), 0);
    chk("R6 rom_cs drops", 128'(rom_cs), 0);
    tick();
    chk("R5 next grant proc1", 128'(bus_gnt), 128'h2);
    host_req = 1'b1;
    tick();
    chk("R7 no host grant mid transfer", 128'(host_gnt), 0);
    chk("R7 proc1 keeps bus", 128'(bus_gnt), 128'h2);
    pulse(4'b0010);
    chk("R7 host still waits at done edge", 128'(host_gnt), 0);
    tick();
    chk("R7 host granted in gap", 128'(host_gnt), 1);
    chk("R7 host precedes proc2", 128'(bus_gnt), 0);
    host_req = 1'b0;
    tick();
    chk("R7 host grant released", 128'(host_gnt), 0);
    tick();
    chk("R5 grant proc2", 128'(bus_gnt), 128'h4);
    pulse(4'b0100);
    tick();
    chk("R5 grant proc3", 128'(bus_gnt), 128'h8);
    chk("R9 run low before last", 128'(run), 0);
    pulse(4'b1000);
    chk("R9 run after last done", 128'(run), 1);
    chk("R6 bus idle at end", 128'(bus_gnt), 0);
    tick();
    tick();
    chk("R9 run stays high", 128'(run), 1);
  endtask

  task automatic t_host_boot();
    start(3'b000, 3'b001);
    chk("R1 R2 noboot lead host group", 128'(boot_mode), 128'h54);
    chk("R4 mixed addresses", start_addr, {BT, BT, BT, NB});
    tick();
    tick();
    chk("R6 no grant without rom mode", 128'({bus_gnt, rom_cs}), 0);
    host_req = 1'b1;
    tick();
    chk("R7 host grant from idle", 128'(host_gnt), 1);
    pulse(4'b0110);
    chk("R8 run waits for proc3", 128'(run), 0);
    pulse(4'b1000);
    chk("R8 R9 run after host loads", 128'(run), 1);
    host_req = 1'b0;
    tick();
  endtask

  task automatic t_frozen();
    start(3'b000, 3'b100);
    strap_lead = 3'b100;
    strap_group = 3'b000;
    tick();
    chk("R3 mode kept after strap change", 128'(boot_mode), 128'hFC);
    chk("R3 addr kept after strap change", start_addr, {BT, BT, BT, NB});
    chk("R5 proc0 noboot skipped", 128'(bus_gnt), 128'h2);
    pulse(4'b1000);
    chk("R8 foreign done ignored", 128'(bus_gnt), 128'h2);
    pulse(4'b0010);
    tick();
    chk("R5 proc2 next", 128'(bus_gnt), 128'h4);
    pulse(4'b0100);
    tick();
    chk("R8 proc3 still pending", 128'(bus_gnt), 128'h8);
    chk("R9 run low", 128'(run), 0);
    pulse(4'b1000);
    chk("R9 run high", 128'(run), 1);
  endtask

  task automatic t_link();
    start(3'b010, 3'b011);
    chk("R1 link modes", 128'(boot_mode), 128'hAA);
    tick();
    chk("R6 link needs no bus", 128'(bus_gnt), 0);
    pulse(4'b0111);
    chk("R8 link run waits", 128'(run), 0);
    pulse(4'b1000);
    chk("R8 link run", 128'(run), 1);
  endtask

  task automatic t_noboot();
    start(3'b000, 3'b000);
    chk("R8 noboot run at capture", 128'(run), 1);
    chk("R4 noboot addr", start_addr, {4{NB}});
    chk("R1 noboot code", 128'(boot_mode), 0);
  endtask

  initial begin
    t_reset();
    t_rom_chain();
    t_host_boot();
    t_frozen();
    t_link();
    t_noboot();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule